// File: doc/BRIEF.md
# External Oscillator Clock Failure Monitor

The block watches a fast external oscillator clock from a trusted internal reference clock. When the external clock stops, it reacts on its own. It counts rising edges of the monitored clock, brought into the reference domain through a two-flop synchronizer, inside fixed windows of reference cycles. A window that ends with too few edges counts as a failure.

On a failure the block forces the external oscillator off and sends a one-cycle break pulse to a timer. It also raises a sticky interrupt flag meant for a non-maskable interrupt line. What it does to the clock tree depends on where the failed clock goes:
- If the failed oscillator drives the system clock, the system clock is forced over to the internal oscillator.
- If the failed oscillator feeds the PLL and the PLL drives the system clock, the system clock is forced over to the internal oscillator and the PLL is also forced off.
- If neither holds, the clock tree is left alone.

Software arms the monitor with an enable bit. Monitoring begins only once the oscillator is on and reports that its startup is done. The forced outputs stay latched until software switches the oscillator on again.

Top module: `ckmon_top`

## Requirements
- R1: Monitoring runs only while `mon_en_i`, `osc_on_i` and `osc_rdy_i` are all 1. If any of them is 0, a stopped external clock raises no output.
- R2: A failure is declared when a window of `WIN_CYC` (default 64) reference cycles sees fewer than `MIN_EDGES` (default 2) synchronized rising edges of `ext_clk_i`. A clock with many edges in every window never fails.
- R3: On a failure, `osc_off_o` goes to 1.
- R4: `brk_o` is a pulse exactly one reference cycle wide for each failure.
- R5: `irq_o` is set on a failure and stays at 1 until `irq_clr_i` is sampled at 1. If a failure and a clear fall in the same cycle, the set wins.
- R6: The `sys_sel_i` encoding is 00 internal, 01 external, 10 PLL, 11 internal. With `sys_sel_i`=01 at a failure, `sys_force_int_o`=1 and `pll_off_o`=0.
- R7: With `sys_sel_i`=10 and `pll_src_ext_i`=1 at a failure, both `sys_force_int_o` and `pll_off_o` go to 1.
- R8: With `sys_sel_i`=00, or with `sys_sel_i`=10 and `pll_src_ext_i`=0, a failure leaves `sys_force_int_o` and `pll_off_o` at 0. `irq_o` and `brk_o` are still raised.
- R9: `osc_off_o`, `sys_force_int_o` and `pll_off_o` stay at 1 even if the clock comes back. They clear on a 0-to-1 transition of `osc_on_i`, which also re-arms monitoring.
- R10: After reset, all outputs are 0.
- R11: While `osc_on_i` is 0, the detector is disarmed and no failure is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_en_i | input | 1 | Software monitor enable |
| osc_on_i | input | 1 | External oscillator switched on |
| osc_rdy_i | input | 1 | External oscillator startup complete |
| ext_clk_i | input | 1 | Monitored external clock |
| sys_sel_i | input | 2 | System clock source: 00 internal, 01 external, 10 PLL, 11 internal |
| pll_src_ext_i | input | 1 | PLL input is the external oscillator |
| irq_clr_i | input | 1 | Clear for the interrupt flag |
| osc_off_o | output | 1 | Forced external oscillator disable |
| pll_off_o | output | 1 | Forced PLL disable |
| sys_force_int_o | output | 1 | Forced switch of the system clock to the internal oscillator |
| brk_o | output | 1 | Timer break pulse |
| irq_o | output | 1 | Sticky failure interrupt |

## Verification
The detector is tried with three kinds of external clock:
- A steadily toggling clock shows that healthy edges never trip the window.
- A clock that stops while armed shows that a failure is declared within two windows.
- A stopped clock with the enable, on or ready input low shows that disarming really suppresses detection.

Every source-select case is driven through a failure (external, PLL on the external clock, PLL on the internal clock, internal). This separates the switch-only, switch-plus-PLL-off and no-action outcomes. A final sequence restarts the clock, checks that the latches hold, toggles the oscillator-on input to release them, and checks that interrupt clearing is independent of those latches.

// File: rtl/ckmon_pkg.sv
package ckmon_pkg;
  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_EXT  = 2'b01,
    SRC_PLL  = 2'b10,
    SRC_RSVD = 2'b11
  } sys_src_e;
endpackage

// File: rtl/ckmon_sync.sv
module ckmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/ckmon_window.sv
module ckmon_window #(
  parameter int WIN_CYC   = 64,
  parameter int MIN_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic edge_i,
  output logic fail_o
);
  localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [CW-1:0] CLAST = CW'(WIN_CYC - 1);
  localparam logic [EW-1:0] EMAX  = EW'(MIN_EDGES);

  logic [CW-1:0] cnt_q;
  logic [EW-1:0] edg_q, edg_nxt;
  logic          last;

  assign last    = (cnt_q == CLAST);
  assign edg_nxt = (edge_i && edg_q < EMAX) ? edg_q + 1'b1 : edg_q;
  assign fail_o  = arm_i && last && (edg_nxt < EMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      edg_q <= '0;
    end else if (!arm_i || last) begin
      cnt_q <= '0;
      edg_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      edg_q <= edg_nxt;
    end
  end

  // R2: edge count saturates at the threshold
  a_r2_edge_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edg_q <= EMAX);
  // R2: window restarts after its last cycle
  a_r2_win_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> cnt_q == '0);
endmodule

// File: rtl/ckmon_react.sv
module ckmon_react
  import ckmon_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fail_i,
  input  sys_src_e src_i,
  input  logic     pll_src_ext_i,
  input  logic     irq_clr_i,
  input  logic     rearm_i,
  output logic     failed_o,
  output logic     pll_off_o,
  output logic     sys_force_o,
  output logic     brk_o,
  output logic     irq_o
);
  logic ext_direct, ext_via_pll;

  assign ext_direct  = (src_i == SRC_EXT);
  assign ext_via_pll = (src_i == SRC_PLL) && pll_src_ext_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      failed_o    <= 1'b0;
      pll_off_o   <= 1'b0;
      sys_force_o <= 1'b0;
      brk_o       <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      brk_o <= fail_i;
      if (fail_i)         irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (fail_i) begin
        failed_o    <= 1'b1;
        sys_force_o <= sys_force_o | ext_direct | ext_via_pll;
        pll_off_o   <= pll_off_o | ext_via_pll;
      end else if (rearm_i) begin
        failed_o    <= 1'b0;
        sys_force_o <= 1'b0;
        pll_off_o   <= 1'b0;
      end
    end
  end

  a_r4_brk_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |=> !brk_o);
  a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  a_r3_brk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (failed_o && irq_o));
  a_r7_pll_implies_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_off_o |-> sys_force_o);
endmodule

// File: rtl/ckmon_top.sv
module ckmon_top
  import ckmon_pkg::*;
#(
  parameter int WIN_CYC     = 64,
  parameter int MIN_EDGES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mon_en_i,
  input  logic       osc_on_i,
  input  logic       osc_rdy_i,
  input  logic       ext_clk_i,
  input  logic [1:0] sys_sel_i,
  input  logic       pll_src_ext_i,
  input  logic       irq_clr_i,
  output logic       osc_off_o,
  output logic       pll_off_o,
  output logic       sys_force_int_o,
  output logic       brk_o,
  output logic       irq_o
);
  logic ck_s, ck_prev_q, on_q, rise, armed, rearm, fail;

  ckmon_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .q_o(ck_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_prev_q <= 1'b0;
      on_q      <= 1'b0;
    end else begin
      ck_prev_q <= ck_s;
      on_q      <= osc_on_i;
    end
  end

  assign rise  = ck_s && !ck_prev_q;
  assign rearm = osc_on_i && !on_q;
  // disarmed after a failure until the oscillator is switched on again
  assign armed = mon_en_i && osc_on_i && osc_rdy_i && !osc_off_o;

  ckmon_window #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) i_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(armed), .edge_i(rise), .fail_o(fail)
  );

  ckmon_react i_react (
    .clk_i(clk_i), .rst_ni(rst_ni), .fail_i(fail),
    .src_i(sys_src_e'(sys_sel_i)), .pll_src_ext_i(pll_src_ext_i),
    .irq_clr_i(irq_clr_i), .rearm_i(rearm), .failed_o(osc_off_o),
    .pll_off_o(pll_off_o), .sys_force_o(sys_force_int_o),
    .brk_o(brk_o), .irq_o(irq_o)
  );

  a_r1_armed_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past(mon_en_i && osc_on_i && osc_rdy_i));
  a_r8_int_no_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && $past(sys_sel_i == 2'b00) && !$past(sys_force_int_o)) |-> !sys_force_int_o);
endmodule

// File: tb/test_ckmon_top.sv
module test_ckmon_top;
  logic clk = 0, rst_n = 0;
  logic mon_en = 0, osc_on = 0, osc_rdy = 0, ext_clk = 0, pll_ext = 0, irq_clr = 0;
  logic [1:0] sel = 2'b00;
  logic ext_run = 0;
  logic osc_off, pll_off, sw, brk, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  initial forever begin #30; if (ext_run) ext_clk = ~ext_clk; end

  ckmon_top i_ckmon_top (
    .clk_i(clk), .rst_ni(rst_n), .mon_en_i(mon_en), .osc_on_i(osc_on),
    .osc_rdy_i(osc_rdy), .ext_clk_i(ext_clk), .sys_sel_i(sel),
    .pll_src_ext_i(pll_ext), .irq_clr_i(irq_clr), .osc_off_o(osc_off),
    .pll_off_o(pll_off), .sys_force_int_o(sw), .brk_o(brk), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; mon_en = 0; osc_on = 0; osc_rdy = 0; irq_clr = 0;
    ext_run = 0; sel = 2'b00; pll_ext = 0;
    cyc(3); rst_n = 1; cyc(2);
  endtask

  // waits for a break pulse; reports count of pulses seen and whether any pulse was wider than 1
  task automatic watch(input int n, output int pulses, output bit wide);
    bit prev = 0;
    pulses = 0; wide = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (brk && !prev) pulses++;
      if (brk && prev) wide = 1;
      prev = brk;
    end
  endtask

  task automatic arm_and_stop(input logic [1:0] s, input logic pe);
    do_reset();
    sel = s; pll_ext = pe; ext_run = 1;
    mon_en = 1; osc_on = 1; osc_rdy = 1;
    cyc(150);
    ext_run = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 outputs", {osc_off, pll_off, sw, brk, irq}, 5'b0);
  endtask

  task automatic t_healthy();
    int p; bit w;
    do_reset();
    sel = 2'b01; ext_run = 1; mon_en = 1; osc_on = 1; osc_rdy = 1;
    watch(400, p, w);
    chk("R2 healthy no break", p, 0);
    chk("R2 healthy no irq", irq, 0);
  endtask

  task automatic t_disarmed();
    int p; bit w;
    do_reset(); sel = 2'b01; mon_en = 0; osc_on = 1; osc_rdy = 1;
    watch(300, p, w);
    chk("R1 enable low", p + irq + osc_off, 0);
    do_reset(); sel = 2'b01; mon_en = 1; osc_on = 1; osc_rdy = 0;
    watch(300, p, w);
    chk("R1 not ready", p + irq + osc_off, 0);
    do_reset(); sel = 2'b01; mon_en = 1; osc_on = 0; osc_rdy = 1;
    watch(300, p, w);
    chk("R11 osc off", p + irq + osc_off, 0);
  endtask

  task automatic t_fail(input logic [1:0] s, input logic pe, input logic exp_sw,
                        input logic exp_pll, input string req);
    int p; bit w;
    arm_and_stop(s, pe);
    watch(200, p, w);
    chk("R2 failure detected", p, 1);
    chk("R4 single cycle break", w, 0);
    chk("R3 osc forced off", osc_off, 1);
    chk("R5 irq set", irq, 1);
    chk({req, " switch"}, sw, exp_sw);
    chk({req, " pll off"}, pll_off, exp_pll);
  endtask

  task automatic t_latch_clear();
    int p; bit w;
    arm_and_stop(2'b10, 1);
    watch(200, p, w);
    ext_run = 1;
    watch(300, p, w);
    chk("R9 latched with clock back", {osc_off, sw, pll_off}, 3'b111);
    chk("R9 no new break", p, 0);
    chk("R5 irq held", irq, 1);
    irq_clr = 1; cyc(1); irq_clr = 0; cyc(1);
    chk("R5 irq cleared", irq, 0);
    chk("R9 clear irq leaves latches", {osc_off, sw, pll_off}, 3'b111);
    osc_on = 0; cyc(2); osc_on = 1; cyc(2);
    chk("R9 released on re-enable", {osc_off, sw, pll_off}, 3'b000);
    watch(300, p, w);
    chk("R9 healthy after re-arm", p, 0);
  endtask

  initial begin
    t_reset();
    t_healthy();
    t_disarmed();
    t_fail(2'b01, 0, 1, 0, "R6");
    t_fail(2'b10, 1, 1, 1, "R7");
    t_fail(2'b10, 0, 0, 0, "R8 pll internal");
    t_fail(2'b00, 1, 0, 0, "R8 internal");
    t_latch_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule